// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM command bus. From reset it holds the bus in a quiet state for a programmable power-up wait. It then brings the memory into service with a fixed command sequence: a close-all-banks precharge, two auto refreshes and a load of the mode register. The op-code for that load is a build parameter. Each command is separated from the next by the device timing it requires, and every cycle with no command is padded with NOP.

Once the sequence completes, the block raises a ready flag and hands the command bus to a user access path. A free-running interval timer asks for one auto refresh each interval. The interval is the retention window divided by the number of refreshes it requires, rounded down to whole clocks. A pending refresh waits until the user path reports that every bank is closed. The block then takes the bus, issues one auto refresh, waits out the refresh cycle time and gives the bus back.

The hand-off works as follows. The user path may drive the bus only while `bus_grant` is high. `bus_grant` drops combinationally in the same cycle that `refresh_req` and `usr_banks_idle` are both high. The user's pins are ignored from that cycle until the grant returns, so the user cannot hold the refresh off except by keeping a bank open.

Top module: `sdram_boot_refresh_seq`

## Requirements
- R1: In reset and for at least `PWR_WAIT_CYC` clocks after reset release, the bus carries only NOP, with {cs_n,ras_n,cas_n,we_n}=0111. `init_done`, `refresh_req` and `bus_grant` are low in reset.
- R2: The first command after the wait is a precharge (0010) with address bit `AP_BIT` high, which closes all banks.
- R3: The first auto refresh (0001) comes exactly `RP_CYC` clocks after the precharge. The second comes exactly `RC_CYC` clocks after the first.
- R4: A mode load (0000) comes exactly `RC_CYC` clocks after the second refresh, with the address equal to `MODE_WORD` and the bank address zero. The mode word carries the CAS latency in bits 6:4 (010 or 011) and has bits 8:7 at 00.
- R5: `init_done` rises exactly `MRD_CYC` clocks after the mode load and stays high until reset. `bus_grant` is low while `init_done` is low.
- R6: Clock enable is high in every cycle. Every cycle that carries no command from the block drives NOP with chip select low.
- R7: `refresh_req` is set every floor(`RETAIN_WINDOW_CYC`/`RETAIN_REFRESHES`) clocks, counted from the rise of `init_done`. It stays set until that request is served.
- R8: While `bus_grant` is high, the bus outputs equal the user command, address and bank pins. While `refresh_req` is high and `usr_banks_idle` is low, the request stays pending and the grant stays high.
- R9: In a cycle with `refresh_req` and `usr_banks_idle` both high, `bus_grant` is low and NOP is driven. The next cycle carries auto refresh (0001). The grant returns exactly `RC_CYC` clocks after that refresh, and the request is cleared unless a new interval expired at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_cs_n | input | 1 | User path chip select |
| usr_ras_n | input | 1 | User path row strobe |
| usr_cas_n | input | 1 | User path column strobe |
| usr_we_n | input | 1 | User path write enable |
| usr_addr | input | ADDR_W | User path address |
| usr_ba | input | BA_W | User path bank address |
| usr_banks_idle | input | 1 | User path reports all banks closed |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select to memory |
| sd_ras_n | output | 1 | Row strobe to memory |
| sd_cas_n | output | 1 | Column strobe to memory |
| sd_we_n | output | 1 | Write enable to memory |
| sd_addr | output | ADDR_W | Address to memory |
| sd_ba | output | BA_W | Bank address to memory |
| init_done | output | 1 | Power-up sequence complete |
| refresh_req | output | 1 | Auto refresh pending |
| bus_grant | output | 1 | User path owns the bus this cycle |

## Verification
The bench builds the block with a 50-clock power-up wait, `RP_CYC`=3, `RC_CYC`=7 and `MRD_CYC`=2, so the whole start-up sequence fits in under a hundred cycles. The retention window is 2010 clocks over 16 refreshes. That gives a 125-clock interval whose quotient is not exact, which brings the rounding down within reach, along with about twenty refresh rounds in one run. A 300-clock stretch with banks held open makes the timer expire while a request is already pending.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sdr_pins_t;

  localparam sdr_pins_t PINS_NOP = 4'b0111;
  localparam sdr_pins_t PINS_PRE = 4'b0010;
  localparam sdr_pins_t PINS_REF = 4'b0001;
  localparam sdr_pins_t PINS_LMR = 4'b0000;

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_ISSUE_PRE,
    ST_GAP_RP,
    ST_ISSUE_REF1,
    ST_GAP_RC1,
    ST_ISSUE_REF2,
    ST_GAP_RC2,
    ST_ISSUE_LMR,
    ST_GAP_MRD,
    ST_USER,
    ST_ISSUE_RREF,
    ST_GAP_RRC
  } seq_state_t;

  function automatic sdr_pins_t state_pins(seq_state_t s);
    case (s)
      ST_ISSUE_PRE:  return PINS_PRE;
      ST_ISSUE_REF1,
      ST_ISSUE_REF2,
      ST_ISSUE_RREF: return PINS_REF;
      ST_ISSUE_LMR:  return PINS_LMR;
      default:       return PINS_NOP;
    endcase
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_gap_counter.sv
module sdr_gap_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= CNT_W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int unsigned TMR_W = $clog2(INTERVAL + 1);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(INTERVAL - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             expire;

  assign expire = run && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr_q <= RELOAD;
    else if (!run || expire)   tmr_q <= RELOAD;
    else                       tmr_q <= tmr_q - 1'b1;
  end

  // a fresh expiry wins over a same-edge acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (expire)  pending <= 1'b1;
    else if (ack)     pending <= 1'b0;
  end
endmodule

// File: rtl/sdr_bus_mux.sv
module sdr_bus_mux
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 2
) (
  input  logic              grant,
  input  sdr_pins_t         own_pins,
  input  logic [ADDR_W-1:0] own_addr,
  input  sdr_pins_t         usr_pins,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [BA_W-1:0]   usr_ba,
  output sdr_pins_t         bus_pins,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BA_W-1:0]   bus_ba
);
  always_comb begin
    if (grant) begin
      bus_pins = usr_pins;
      bus_addr = usr_addr;
      bus_ba   = usr_ba;
    end else begin
      bus_pins = own_pins;
      bus_addr = own_addr;
      bus_ba   = '0;
    end
  end
endmodule

// File: rtl/sdram_boot_refresh_seq.sv
module sdram_boot_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W            = 11,
  parameter int unsigned BA_W              = 2,
  parameter int unsigned AP_BIT            = 10,
  parameter int unsigned PWR_WAIT_CYC      = 10000,
  parameter int unsigned RP_CYC            = 2,
  parameter int unsigned RC_CYC            = 7,
  parameter int unsigned MRD_CYC           = 2,
  parameter int unsigned RETAIN_WINDOW_CYC = 6400000,
  parameter int unsigned RETAIN_REFRESHES  = 4096,
  parameter logic [ADDR_W-1:0] MODE_WORD   = 'h022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_cs_n,
  input  logic              usr_ras_n,
  input  logic              usr_cas_n,
  input  logic              usr_we_n,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [BA_W-1:0]   usr_ba,
  input  logic              usr_banks_idle,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              refresh_req,
  output logic              bus_grant
);
  localparam int unsigned INTERVAL = RETAIN_WINDOW_CYC / RETAIN_REFRESHES;
  localparam int unsigned GAP_MAX  =
    max_of(max_of(PWR_WAIT_CYC, RC_CYC), max_of(RP_CYC, MRD_CYC));
  localparam int unsigned CNT_W    = $clog2(GAP_MAX + 1);

  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(RP_CYC - 2);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(RC_CYC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(MRD_CYC - 2);

  seq_state_t        state_q, state_d;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  logic              gap_done;
  logic              take;
  logic [ADDR_W-1:0] own_addr;
  sdr_pins_t         bus_pins;

  assign take      = (state_q == ST_USER) && refresh_req && usr_banks_idle;
  assign bus_grant = (state_q == ST_USER) && !take;
  assign sd_cke    = 1'b1;

  sdr_gap_counter #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWR_WAIT_CYC - 1)
  ) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_done)
  );

  sdr_refresh_timer #(
    .INTERVAL (INTERVAL)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (init_done),
    .ack     (take),
    .pending (refresh_req)
  );

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    gap_val  = '0;
    case (state_q)
      ST_PWR_WAIT:   if (gap_done) state_d = ST_ISSUE_PRE;
      ST_ISSUE_PRE:  begin gap_load = 1'b1; gap_val = LD_RP;  state_d = ST_GAP_RP;  end
      ST_GAP_RP:     if (gap_done) state_d = ST_ISSUE_REF1;
      ST_ISSUE_REF1: begin gap_load = 1'b1; gap_val = LD_RC;  state_d = ST_GAP_RC1; end
      ST_GAP_RC1:    if (gap_done) state_d = ST_ISSUE_REF2;
      ST_ISSUE_REF2: begin gap_load = 1'b1; gap_val = LD_RC;  state_d = ST_GAP_RC2; end
      ST_GAP_RC2:    if (gap_done) state_d = ST_ISSUE_LMR;
      ST_ISSUE_LMR:  begin gap_load = 1'b1; gap_val = LD_MRD; state_d = ST_GAP_MRD; end
      ST_GAP_MRD:    if (gap_done) state_d = ST_USER;
      ST_USER:       if (take) state_d = ST_ISSUE_RREF;
      ST_ISSUE_RREF: begin gap_load = 1'b1; gap_val = LD_RC;  state_d = ST_GAP_RRC; end
      ST_GAP_RRC:    if (gap_done) state_d = ST_USER;
      default:       state_d = ST_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PWR_WAIT;
      init_done <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_GAP_MRD && state_d == ST_USER) init_done <= 1'b1;
    end
  end

  always_comb begin
    own_addr = '0;
    if (state_q == ST_ISSUE_PRE)      own_addr[AP_BIT] = 1'b1;
    else if (state_q == ST_ISSUE_LMR) own_addr = MODE_WORD;
  end

  sdr_bus_mux #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_mux (
    .grant    (bus_grant),
    .own_pins (state_pins(state_q)),
    .own_addr (own_addr),
    .usr_pins ({usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n}),
    .usr_addr (usr_addr),
    .usr_ba   (usr_ba),
    .bus_pins (bus_pins),
    .bus_addr (sd_addr),
    .bus_ba   (sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_pins;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned AP_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h022
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              init_done,
  input logic              refresh_req,
  input logic              bus_grant,
  input logic              usr_banks_idle
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke) else $error("cke low"); // R6

  AST_BOOT_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000))
    else $error("bad boot command"); // R1

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 4'b0010) |-> sd_addr[AP_BIT]) else $error("precharge not all"); // R2

  AST_LMR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 4'b0000) |-> (sd_addr == MODE_WORD && sd_ba == '0))
    else $error("mode load word"); // R4

  AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !bus_grant) else $error("grant before ready"); // R5

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done) else $error("ready dropped"); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !usr_banks_idle) |=> refresh_req) else $error("request lost"); // R8

  AST_TAKE_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && refresh_req && usr_banks_idle && !$past(bus_grant) && $past(init_done) && cmd == 4'b0111
     && !$past(refresh_req && usr_banks_idle) && !bus_grant) |=> (cmd == 4'b0001 || cmd == 4'b0111))
    else $error("take without refresh"); // R9

  AST_REF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cmd == 4'b0001 && !bus_grant) |=> !bus_grant) else $error("grant early"); // R9
endmodule

bind sdram_boot_refresh_seq sdr_seq_checker #(
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .AP_BIT    (AP_BIT),
  .MODE_WORD (MODE_WORD)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sd_cke         (sd_cke),
  .sd_cs_n        (sd_cs_n),
  .sd_ras_n       (sd_ras_n),
  .sd_cas_n       (sd_cas_n),
  .sd_we_n        (sd_we_n),
  .sd_addr        (sd_addr),
  .sd_ba          (sd_ba),
  .init_done      (init_done),
  .refresh_req    (refresh_req),
  .bus_grant      (bus_grant),
  .usr_banks_idle (usr_banks_idle)
);

// File: tb/sdram_boot_refresh_seq_bench.sv
module sdram_boot_refresh_seq_bench;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned BA_W   = 2;
  localparam int unsigned AP_BIT = 10;
  localparam int unsigned PWR    = 50;
  localparam int unsigned TRP    = 3;
  localparam int unsigned TRC    = 7;
  localparam int unsigned TMRD   = 2;
  localparam int unsigned WIN    = 2010;
  localparam int unsigned NREF   = 16;
  localparam logic [ADDR_W-1:0] MODE = 11'h023;

  function automatic int unsigned exp_interval(int unsigned w, int unsigned n);
    return w / n;
  endfunction
  localparam int unsigned IVL = exp_interval(WIN, NREF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr_cs_n = 1'b0, usr_ras_n = 1'b1, usr_cas_n = 1'b1, usr_we_n = 1'b1;
  logic [ADDR_W-1:0] usr_addr = '0;
  logic [BA_W-1:0]   usr_ba = '0;
  logic usr_banks_idle = 1'b0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ADDR_W-1:0] sd_addr;
  logic [BA_W-1:0]   sd_ba;
  logic init_done, refresh_req, bus_grant;

  always #5 clk = ~clk;

  sdram_boot_refresh_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .PWR_WAIT_CYC(PWR),
    .RP_CYC(TRP), .RC_CYC(TRC), .MRD_CYC(TMRD),
    .RETAIN_WINDOW_CYC(WIN), .RETAIN_REFRESHES(NREF), .MODE_WORD(MODE)
  ) u_sdram_boot_refresh_seq (
    .clk(clk), .rst_n(rst_n),
    .usr_cs_n(usr_cs_n), .usr_ras_n(usr_ras_n), .usr_cas_n(usr_cas_n), .usr_we_n(usr_we_n),
    .usr_addr(usr_addr), .usr_ba(usr_ba), .usr_banks_idle(usr_banks_idle),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .init_done(init_done), .refresh_req(refresh_req), .bus_grant(bus_grant)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit mon_on = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- monitor and reference model ----------------
  int cyc = 0;
  int n_evt = 0;
  int evt_cyc [8];
  logic [3:0] evt_cmd [8];
  logic [ADDR_W-1:0] evt_addr [8];
  logic [BA_W-1:0] evt_ba [8];
  bit ready_seen = 0;
  int rdy_cyc = 0;
  bit m_req = 0;
  bit m_own = 0;
  int m_k = 0;
  int m_t = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic boot_checks();
    chk(n_evt == 4, "R1 boot command count", n_evt, 4);
    chk(evt_cmd[0] == 4'b0010, "R2 first command precharge", evt_cmd[0], 4'b0010);
    chk(evt_cyc[0] >= int'(PWR), "R1 power-up wait", evt_cyc[0], PWR);
    chk(evt_addr[0][AP_BIT] == 1'b1, "R2 precharge all bit", evt_addr[0][AP_BIT], 1);
    chk(evt_cmd[1] == 4'b0001 && evt_cmd[2] == 4'b0001, "R3 two refreshes",
        {evt_cmd[1], evt_cmd[2]}, 8'h11);
    chk(evt_cyc[1] - evt_cyc[0] == int'(TRP), "R3 precharge to refresh", evt_cyc[1] - evt_cyc[0], TRP);
    chk(evt_cyc[2] - evt_cyc[1] == int'(TRC), "R3 refresh to refresh", evt_cyc[2] - evt_cyc[1], TRC);
    chk(evt_cmd[3] == 4'b0000, "R4 mode load command", evt_cmd[3], 0);
    chk(evt_cyc[3] - evt_cyc[2] == int'(TRC), "R4 refresh to mode load", evt_cyc[3] - evt_cyc[2], TRC);
    chk(evt_addr[3] == MODE && evt_ba[3] == '0, "R4 mode word and bank", evt_addr[3], MODE);
    chk((evt_addr[3][6:4] == 3'b010 || evt_addr[3][6:4] == 3'b011) && evt_addr[3][8:7] == 2'b00,
        "R4 mode fields legal", evt_addr[3], MODE);
    chk(rdy_cyc - evt_cyc[3] == int'(TMRD), "R5 ready after mode load", rdy_cyc - evt_cyc[3], TMRD);
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on && !finished) begin
      logic [3:0] cmd;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      chk(sd_cke == 1'b1, "R6 clock enable", sd_cke, 1);
      if (!ready_seen && !init_done) begin
        chk(bus_grant == 1'b0, "R5 no grant before ready", bus_grant, 0);
        if (cmd != 4'b0111 && n_evt < 8) begin
          evt_cyc[n_evt] = cyc; evt_cmd[n_evt] = cmd;
          evt_addr[n_evt] = sd_addr; evt_ba[n_evt] = sd_ba;
          n_evt++;
        end
      end else begin
        bit take, eg, set;
        logic [3:0] ecmd;
        if (!ready_seen) begin
          ready_seen = 1; rdy_cyc = cyc;
          m_req = 0; m_own = 0; m_k = 0; m_t = IVL - 1;
          boot_checks();
        end
        chk(init_done == 1'b1, "R5 ready stays high", init_done, 1);
        take = m_req && usr_banks_idle;
        if (!m_own) begin
          eg = !take;
          ecmd = take ? 4'b0111 : {usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n};
        end else begin
          eg = 0;
          ecmd = (m_k == 0) ? 4'b0001 : 4'b0111;
        end
        chk(refresh_req == m_req, "R7 refresh request timing", refresh_req, m_req);
        chk(bus_grant == eg, "R9 grant ownership", bus_grant, eg);
        chk(cmd == ecmd, eg ? "R8 user pass-through" : "R9 block command", cmd, ecmd);
        if (eg) chk(sd_addr == usr_addr && sd_ba == usr_ba, "R8 user address",
                    {sd_ba, sd_addr}, {usr_ba, usr_addr});
        else    chk(sd_ba == '0, "R6 idle bank lines", sd_ba, 0);
        if (m_own) m_k = (m_k == int'(TRC) - 1) ? 0 : m_k + 1;
        set = (m_t == 0);
        m_t = set ? IVL - 1 : m_t - 1;
        if (m_own) begin
          if (m_k == 0) m_own = 0;
        end else if (take) begin
          m_own = 1; m_k = 0;
        end
        m_req = set | (m_req & !take);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_user(int idle_pct);
    @(posedge clk); #1;
    usr_banks_idle = (($urandom % 100) < idle_pct);
    {usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n} = 4'($urandom);
    usr_addr = ADDR_W'($urandom);
    usr_ba = BA_W'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5D1A_0E42));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset command NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!init_done && !refresh_req && !bus_grant, "R1 reset flags",
        {init_done, refresh_req, bus_grant}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1; mon_on = 1;
    while (!init_done) drive_user(0);
    for (int i = 0; i < 600; i++) drive_user(25);
    for (int i = 0; i < 300; i++) drive_user(0);     // banks held open: R8
    for (int i = 0; i < 400; i++) drive_user(100);   // always idle: R9
    for (int i = 0; i < 1200; i++) drive_user(50);
    @(posedge clk); #1;
    mon_on = 0; rst_n = 1'b0;
    @(negedge clk);
    chk(!init_done && !refresh_req && !bus_grant, "R1 mid-run reset flags",
        {init_done, refresh_req, bus_grant}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 mid-run reset NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule